// File: doc/BRIEF.md
# Battery Charge Safety Timer

This block limits how long a battery charger may stay in any one charging stage. It keeps a separate elapsed-time counter for each of the trickle, pre-charge and fast-charge stages. A counter advances on a slow time-base tick, but only while its stage is the one in progress and the global timer enable is set. The trickle limit is fixed at one hour. The pre-charge and fast-charge limits are selected by small codes.

When the active stage's counter reaches its limit, the block raises a charge-stop request and a live expiry status. It also sets a sticky expiry flag that the host clears with a read strobe. The stage sequencer reacts to the stop request by reporting the "not charging" status code 000 and ending charging. Converter operation and the supply to the system load are not involved.

Counting slows to half rate while a current-reduction condition is present and half-rate mode is enabled. Counting freezes during a charge-suspending fault and later resumes from the held count. All limits are given in ticks through a ticks-per-hour parameter.

Top module: `chg_safety_tmr`

## Requirements
- R1: After reset `chg_stop_o`, `tmr_stat_o` and `tmr_flag_o` are 0 and all stage counters are 0.
- R2: A counter advances only on a cycle where `tick_i` is 1, `tmr_en_i` is 1 and `stage_i` selects its stage (01 trickle, 10 pre-charge, 11 fast). With `stage_i` = 00 nothing counts and nothing expires.
- R3: The trickle limit is always TICKS_PER_HOUR ticks.
- R4: The pre-charge limit is TICKS_PER_HOUR/2 ticks when `pre_lim_i` = 0 and 2·TICKS_PER_HOUR ticks when `pre_lim_i` = 1.
- R5: The fast-charge limit is 5, 8, 12 or 24 hours of ticks for `fast_lim_i` = 00, 01, 10 or 11.
- R6: While `half_rate_en_i` and `curr_red_i` are both 1, the active counter advances on every second qualifying tick. The skip/advance phase is held across fault periods and is cleared on stage entry or a new cycle.
- R7: While `fault_i` is 1, no counter and no rate phase changes, whatever `half_rate_en_i` says. Counting resumes from the held values once the fault clears.
- R8: Expiry is detected one cycle after the active counter reaches its limit. From the next edge, `chg_stop_o` and `tmr_stat_o` are 1 and stay 1 until `new_cycle_i` pulses or `tmr_en_i` goes to 0.
- R9: `tmr_flag_o` is set on the edge where expiry begins and stays set until a cycle with `flag_rd_i` = 1. If expiry begins in that same cycle, the set takes priority.
- R10: With `tmr_en_i` = 0, no expiry occurs and counters hold. `chg_stop_o` falls one edge after the enable drops. Setting the enable in the middle of a stage resumes counting for that stage.
- R11: When `stage_i` switches to a stage different from the previous cycle's stage, that stage's counter restarts from 0. `new_cycle_i` clears every counter and the expiry state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base tick, one cycle wide |
| stage_i | input | 2 | Active stage: 00 none, 01 trickle, 10 pre-charge, 11 fast |
| new_cycle_i | input | 1 | Start of a new charge cycle |
| tmr_en_i | input | 1 | Global safety timer enable |
| half_rate_en_i | input | 1 | Allow half-rate counting |
| curr_red_i | input | 1 | Charge current is being reduced |
| fault_i | input | 1 | Charge-suspending fault present |
| pre_lim_i | input | 1 | Pre-charge limit code |
| fast_lim_i | input | 2 | Fast-charge limit code |
| flag_rd_i | input | 1 | Host read strobe, clears the sticky flag |
| chg_stop_o | output | 1 | Request to stop charging |
| tmr_stat_o | output | 1 | Live expiry status |
| tmr_flag_o | output | 1 | Sticky expiry flag |

## Verification
The bench builds the block with TICKS_PER_HOUR = 8. This gives limits of 4 to 192 ticks, so every pre-charge and fast-charge code, including the 24-hour one at half rate, reaches expiry within a few hundred cycles. With ticks every second cycle, directed runs and a random phase can exercise faults, half-rate phases and stage re-entry around each limit. A reference model is compared against the outputs on every clock.

// File: rtl/chg_tmr_pkg.sv
package chg_tmr_pkg;
  typedef enum logic [1:0] {
    STG_NONE = 2'b00,
    STG_TRKL = 2'b01,
    STG_PRE  = 2'b10,
    STG_FAST = 2'b11
  } stage_e;

  localparam int unsigned NUM_STG = 3;
  localparam int unsigned MAX_HOURS = 24;
endpackage

// File: rtl/chg_tmr_limits.sv
module chg_tmr_limits
  import chg_tmr_pkg::*;
#(
  parameter int unsigned TPH   = 3600,
  parameter int unsigned CNT_W = 17
) (
  input  logic                          pre_sel_i,
  input  logic [1:0]                    fast_sel_i,
  output logic [NUM_STG:0][CNT_W-1:0]   lim_o
);
  localparam logic [CNT_W-1:0] L_TRKL = CNT_W'(TPH);
  localparam logic [CNT_W-1:0] L_PRE0 = CNT_W'(TPH / 2);
  localparam logic [CNT_W-1:0] L_PRE1 = CNT_W'(2 * TPH);
  localparam logic [CNT_W-1:0] L_F5   = CNT_W'(5 * TPH);
  localparam logic [CNT_W-1:0] L_F8   = CNT_W'(8 * TPH);
  localparam logic [CNT_W-1:0] L_F12  = CNT_W'(12 * TPH);
  localparam logic [CNT_W-1:0] L_F24  = CNT_W'(MAX_HOURS * TPH);

  always_comb begin
    lim_o           = '0;
    lim_o[STG_TRKL] = L_TRKL;
    lim_o[STG_PRE]  = pre_sel_i ? L_PRE1 : L_PRE0;
    unique case (fast_sel_i)
      2'b00:   lim_o[STG_FAST] = L_F5;
      2'b01:   lim_o[STG_FAST] = L_F8;
      2'b10:   lim_o[STG_FAST] = L_F12;
      default: lim_o[STG_FAST] = L_F24;
    endcase
  end
endmodule

// File: rtl/chg_tmr_rate.sv
module chg_tmr_rate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic qual_i,
  input  logic half_i,
  output logic step_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              tog_q <= 1'b0;
    else if (clr_i)           tog_q <= 1'b0;
    else if (qual_i && half_i) tog_q <= ~tog_q;
  end

  // half rate: advance on the second of each pair of qualified ticks
  assign step_o = qual_i && (!half_i || tog_q);

  AST_HALF_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && half_i) |=> (!step_o || !half_i)); // R6
endmodule

// File: rtl/chg_tmr_stage_cnt.sv
module chg_tmr_stage_cnt #(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R2
endmodule

// File: rtl/chg_safety_tmr.sv
module chg_safety_tmr
  import chg_tmr_pkg::*;
#(
  parameter int unsigned TICKS_PER_HOUR = 3600,
  localparam int unsigned CNT_W = $clog2(MAX_HOURS * TICKS_PER_HOUR + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] stage_i,
  input  logic       new_cycle_i,
  input  logic       tmr_en_i,
  input  logic       half_rate_en_i,
  input  logic       curr_red_i,
  input  logic       fault_i,
  input  logic       pre_lim_i,
  input  logic [1:0] fast_lim_i,
  input  logic       flag_rd_i,
  output logic       chg_stop_o,
  output logic       tmr_stat_o,
  output logic       tmr_flag_o
);
  logic [1:0]                  prev_stage_q;
  logic                        expired_q, flag_q;
  logic [NUM_STG:0][CNT_W-1:0] lim_all, cnt_all;
  logic                        act, entry, hit, set_evt, qual, step, rate_clr;
  logic [CNT_W-1:0]            cnt_sel, lim_sel;

  chg_tmr_limits #(.TPH(TICKS_PER_HOUR), .CNT_W(CNT_W)) u_limits (
    .pre_sel_i (pre_lim_i),
    .fast_sel_i(fast_lim_i),
    .lim_o     (lim_all)
  );

  assign act     = (stage_i != STG_NONE);
  assign entry   = act && (stage_i != prev_stage_q);
  assign cnt_sel = cnt_all[stage_i];
  assign lim_sel = lim_all[stage_i];

  // expiry judged on the count held at the start of the cycle
  assign hit     = tmr_en_i && act && !entry && !new_cycle_i && (cnt_sel >= lim_sel);
  assign set_evt = hit && !expired_q;

  assign qual     = tick_i && tmr_en_i && act && !fault_i && !expired_q &&
                    !entry && !new_cycle_i && (cnt_sel < lim_sel);
  assign rate_clr = new_cycle_i || entry;

  chg_tmr_rate u_rate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (rate_clr),
    .qual_i(qual),
    .half_i(half_rate_en_i && curr_red_i),
    .step_o(step)
  );

  assign cnt_all[0] = '0;
  for (genvar k = 1; k <= NUM_STG; k++) begin : g_stage
    logic sel_k;
    assign sel_k = (stage_i == 2'(k));
    chg_tmr_stage_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (new_cycle_i || (entry && sel_k)),
      .inc_i (step && sel_k),
      .cnt_o (cnt_all[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_stage_q <= STG_NONE;
      expired_q    <= 1'b0;
      flag_q       <= 1'b0;
    end else begin
      prev_stage_q <= stage_i;
      if (new_cycle_i || !tmr_en_i) expired_q <= 1'b0;
      else if (hit)                 expired_q <= 1'b1;
      if (set_evt)        flag_q <= 1'b1;
      else if (flag_rd_i) flag_q <= 1'b0;
    end
  end

  assign chg_stop_o = expired_q;
  assign tmr_stat_o = expired_q;
  assign tmr_flag_o = flag_q;

  AST_EN_LOW_NO_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_en_i |=> !chg_stop_o); // R10
  AST_FAULT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && !new_cycle_i && !entry) |=> (cnt_all == $past(cnt_all))); // R7
  AST_FLAG_ON_EXPIRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmr_stat_o) |-> tmr_flag_o); // R9
  AST_FLAG_READ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_rd_i && !set_evt) |=> !tmr_flag_o); // R9
  AST_NEW_CYCLE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_cycle_i |=> (!chg_stop_o && cnt_all == '0)); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act && !new_cycle_i) |=> (cnt_all == $past(cnt_all) && !$rose(chg_stop_o))); // R2
endmodule

// File: tb/chg_safety_tmr_tb_top.sv
module chg_safety_tmr_tb_top;
  localparam int CLK_PER = 10;
  localparam int TPH     = 8;
  localparam int WDOG    = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, nc = 1'b0, en = 1'b0, hre = 1'b0, red = 1'b0, flt = 1'b0;
  logic pre = 1'b0, rd = 1'b0;
  logic [1:0] stage = 2'b00, fast = 2'b00;
  logic stop_o, stat_o, flag_o;
  logic tick_on = 1'b0;
  int   n_vec = 0, n_err = 0, cyc = 0;
  string cur_req = "R1";

  always #(CLK_PER/2) clk = ~clk;

  chg_safety_tmr #(.TICKS_PER_HOUR(TPH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .stage_i(stage),
    .new_cycle_i(nc), .tmr_en_i(en), .half_rate_en_i(hre), .curr_red_i(red),
    .fault_i(flt), .pre_lim_i(pre), .fast_lim_i(fast), .flag_rd_i(rd),
    .chg_stop_o(stop_o), .tmr_stat_o(stat_o), .tmr_flag_o(flag_o)
  );

  // reference model
  int m_cnt[4];
  int m_prev;
  bit m_tog, m_exp, m_flag;

  function automatic int lim_of(int s);
    case (s)
      1: return TPH;
      2: return pre ? 2 * TPH : TPH / 2;
      3: case (fast) 0: return 5*TPH; 1: return 8*TPH; 2: return 12*TPH; default: return 24*TPH; endcase
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_prev = 0; m_tog = 0; m_exp = 0; m_flag = 0;
    end else begin
      int a;
      bit ent, hit, set, q, half, exp_n;
      a    = int'(stage);
      ent  = (a != 0) && (a != m_prev);
      hit  = en && a != 0 && !ent && !nc && m_cnt[a] >= lim_of(a);
      set  = hit && !m_exp;
      half = hre && red;
      q    = tick && en && a != 0 && !flt && !m_exp && !ent && !nc && m_cnt[a] < lim_of(a);
      exp_n = (nc || !en) ? 1'b0 : (hit ? 1'b1 : m_exp);
      if (nc) begin
        foreach (m_cnt[i]) m_cnt[i] = 0;
        m_tog = 0;
      end else if (ent) begin
        m_cnt[a] = 0;
        m_tog = 0;
      end else if (q) begin
        if (!half) m_cnt[a]++;
        else begin
          if (m_tog) m_cnt[a]++;
          m_tog = !m_tog;
        end
      end
      m_exp  = exp_n;
      m_flag = set || (m_flag && !rd);
      m_prev = a;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_vec++;
      if (stop_o !== m_exp || stat_o !== m_exp || flag_o !== m_flag) begin
        n_err++;
        $display("FAIL %s cyc %0d: stop/stat/flag act %b%b%b exp %b%b%b",
                 cur_req, cyc, stop_o, stat_o, flag_o, m_exp, m_exp, m_flag);
      end
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    tick <= tick_on && cyc[0];
  end

  always @(posedge clk) if (cyc > WDOG) begin
    n_err++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: act %b exp %b", req, act, exp);
    end
  endtask

  task automatic new_cyc();
    @(negedge clk); nc <= 1'b1;
    @(negedge clk); nc <= 1'b0;
  endtask

  initial begin
    run(3);
    chk("R1", stop_o, 1'b0); chk("R1", stat_o, 1'b0); chk("R1", flag_o, 1'b0);
    rst_n = 1'b1;
    tick_on = 1'b1;

    // trickle fixed limit
    cur_req = "R3"; en <= 1'b1; stage <= 2'b01; new_cyc();
    run(10); chk("R3", stop_o, 1'b0);
    run(30); chk("R3", stop_o, 1'b1); chk("R8", stat_o, 1'b1); chk("R9", flag_o, 1'b1);
    cur_req = "R9"; rd <= 1'b1; run(1); rd <= 1'b0; run(2);
    chk("R9", flag_o, 1'b0); chk("R8", stat_o, 1'b1);

    // pre-charge codes
    cur_req = "R4"; stage <= 2'b10; pre <= 1'b0; new_cyc();
    run(14); chk("R4", stop_o, 1'b1);
    pre <= 1'b1; new_cyc();
    run(20); chk("R4", stop_o, 1'b0);
    run(20); chk("R4", stop_o, 1'b1);

    // fast-charge codes
    cur_req = "R5"; stage <= 2'b11;
    for (int c = 0; c < 4; c++) begin
      int l;
      fast <= 2'(c); new_cyc();
      l = (c == 0) ? 5 : (c == 1) ? 8 : (c == 2) ? 12 : 24;
      run(2 * l * TPH - 10); chk("R5", stop_o, 1'b0);
      run(20); chk("R5", stop_o, 1'b1);
    end

    // half rate
    cur_req = "R6"; fast <= 2'b00; hre <= 1'b1; red <= 1'b1; new_cyc();
    run(120); chk("R6", stop_o, 1'b0);
    run(60);  chk("R6", stop_o, 1'b1);
    hre <= 1'b0; red <= 1'b0;

    // fault freeze and resume
    cur_req = "R7"; stage <= 2'b01; new_cyc();
    run(8); flt <= 1'b1; hre <= 1'b1; run(100); chk("R7", stop_o, 1'b0);
    flt <= 1'b0; hre <= 1'b0; run(16); chk("R7", stop_o, 1'b1);

    // enable low
    cur_req = "R10"; en <= 1'b0; new_cyc();
    run(100); chk("R10", stop_o, 1'b0);
    en <= 1'b1; run(40); chk("R10", stop_o, 1'b1);
    en <= 1'b0; run(2); chk("R10", stop_o, 1'b0);
    en <= 1'b1; chk("R9", flag_o, 1'b1);

    // stage re-entry clears
    cur_req = "R11"; stage <= 2'b01; new_cyc();
    run(10); stage <= 2'b10; pre <= 1'b1; run(4); stage <= 2'b01;
    run(12); chk("R11", stop_o, 1'b0);
    run(10); chk("R11", stop_o, 1'b1);

    // no stage selected
    cur_req = "R2"; stage <= 2'b00; new_cyc();
    run(100); chk("R2", stop_o, 1'b0);

    // read held through expiry: set wins
    cur_req = "R9"; rd <= 1'b1; stage <= 2'b01; new_cyc();
    run(40); chk("R9", flag_o, 1'b0); chk("R8", stop_o, 1'b1);
    rd <= 1'b0;

    // random mix against the model
    cur_req = "R7";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(63) == 0) stage <= 2'($urandom);
      if ($urandom_range(15) == 0) flt <= ~flt;
      if ($urandom_range(15) == 0) red <= ~red;
      if ($urandom_range(31) == 0) hre <= ~hre;
      if ($urandom_range(255) == 0) en <= ~en;
      if ($urandom_range(127) == 0) pre <= ~pre;
      if ($urandom_range(127) == 0) fast <= 2'($urandom);
      rd <= ($urandom_range(31) == 0);
      nc <= ($urandom_range(511) == 0);
    end
    run(2);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule